// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Mid-Bit Start Validation

This block turns a single asynchronous serial line into parallel characters. The line is first brought into the clock domain through a flop chain. After that it is examined only on cycles where a sampling enable is high. A separate programmable baud divider, outside this block, produces that enable. One bit period is a fixed, parameterised number of these sampling ticks.

Reception is level based. Whenever the enable is set and the synchronised line reads low on a sampling tick, a candidate start bit begins. Half a bit period later the line is read again. If it is still low, the start bit is accepted and the bit-timing counter restarts. Every following bit is then read in its middle, one full period after the previous read: the data bits least significant first, an optional parity bit, and a single stop bit.

On the stop-bit read, the assembled character is copied into the receive buffer and the two error flags are rewritten. A one-cycle interrupt then fires: the completion interrupt for a clean frame, or the error interrupt when parity or framing failed. Dropping the enable stops everything at once, with no side effects.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_data` is all zeros, `parity_err` and `frame_err` are 0, and neither interrupt is high.
- R2: A low line seen on a sampling tick while enabled starts a candidate start bit. If the line reads high again TICKS_PER_BIT/2 ticks later, the receiver goes back to idle and no interrupt or buffer change follows.
- R3: In a clean frame, the DATA_BITS data bits arrive least significant bit first and end up in `rx_data`. `rx_done_irq` is high for exactly one clock, in the same cycle that `rx_data` takes its new value. `rx_data` never changes in a cycle where neither interrupt is high.
- R4: `parity_sel` selects the parity mode, with this encoding:
  - 0: no parity slot; the stop bit directly follows the last data bit.
  - 1: even parity, where the data bits plus the parity bit hold an even number of ones.
  - 2: odd parity, where that total is odd.
  - 3: the parity bit must be 0.
- R5: A parity bit that disagrees with the selected mode sets `parity_err`. That frame raises `rx_err_irq` for one clock instead of `rx_done_irq`.
- R6: A stop bit read as low sets `frame_err` and raises `rx_err_irq` instead of `rx_done_irq`. The buffer still receives the character.
- R7: Both error flags are rewritten at the end of every frame. A clean frame clears them, and `rx_err_irq` only fires with at least one flag set.
- R8: Lowering `rx_en` during a frame abandons it. `rx_data`, `parity_err` and `frame_err` keep their values, and no interrupt fires.
- R9: While `rx_en` is low, line activity is ignored: no frame is received and no interrupt fires.
- R10: Raising `rx_en` while the line is already low starts a frame at once. The half-bit start check is timed from the enable.
- R11: `rx_done_irq` and `rx_err_irq` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; low aborts and holds the receiver idle |
| baud_tick | input | 1 | One-cycle sampling enable from the baud divider |
| parity_sel | input | 2 | Parity mode (see R4) |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | DATA_BITS | Receive buffer |
| rx_done_irq | output | 1 | One-cycle pulse on a clean frame |
| rx_err_irq | output | 1 | One-cycle pulse on a frame with an error |
| parity_err | output | 1 | Parity error of the last completed frame |
| frame_err | output | 1 | Framing error of the last completed frame |

## Verification
Random characters are sent under all four parity modes. A few frames carry a flipped parity bit or a low stop bit, which separates the three possible outcomes: done pulse, error pulse with the parity flag, and error pulse with the framing flag. Directed frames cover the rest:
- All-zeros and all-ones data, which expose bit-order and parity-sense mistakes.
- A low glitch shorter than half a bit, which tells start validation apart from plain edge triggering.
- A frame cut off by dropping the enable, which must leave the buffer and flags untouched.
- A complete frame sent while disabled, which must produce nothing.
- A frame whose start bit is already low when the enable rises, which must still be received.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_ZERO = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   // Returns 1 when the received parity bit disagrees with the mode.
   function automatic logic par_mismatch(input par_mode_e mode,
                                         input logic      data_xor,
                                         input logic      pbit);
      logic bad;
      case (mode)
         PAR_EVEN: bad = data_xor ^ pbit;
         PAR_ODD:  bad = ~(data_xor ^ pbit);
         PAR_ZERO: bad = pbit;
         default:  bad = 1'b0;
      endcase
      return bad;
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= 1'b1;
            else        chain <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
   parameter int TICKS_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic half_hit,
   output logic full_hit
);
   localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
   localparam int HALF  = TICKS_PER_BIT / 2;

   logic [CNT_W-1:0] cnt;

   assign half_hit = tick && (cnt == CNT_W'(HALF - 1));
   assign full_hit = tick && (cnt == CNT_W'(TICKS_PER_BIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (clr)      cnt <= '0;
      else if (full_hit) cnt <= '0;
      else if (tick)     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_en,
   input  logic                 tick,
   input  logic                 line_s,
   input  logic                 half_hit,
   input  logic                 full_hit,
   input  logic [1:0]           parity_sel,
   output logic                 timer_clr,
   output logic [DATA_BITS-1:0] buf_q,
   output logic                 done_q,
   output logic                 err_q,
   output logic                 perr_q,
   output logic                 ferr_q
);
   localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

   rx_state_e            state;
   logic [IDX_W-1:0]     bit_idx;
   logic [DATA_BITS-1:0] shreg;
   logic                 par_bit;
   par_mode_e            mode;
   logic                 pe_now;
   logic                 fe_now;
   logic                 start_ok;

   assign mode     = par_mode_e'(parity_sel);
   assign pe_now   = par_mismatch(mode, ^shreg, par_bit);
   assign fe_now   = ~line_s;
   assign start_ok = (state == ST_START) && half_hit && !line_s;

   // Timer restarts while idle, while disabled and on start acceptance.
   assign timer_clr = !rx_en || (state == ST_IDLE) || start_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_idx <= '0;
         shreg   <= '0;
         par_bit <= 1'b0;
         buf_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         perr_q  <= 1'b0;
         ferr_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (!rx_en) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (tick && !line_s) state <= ST_START;
               end
               ST_START: begin
                  if (half_hit) begin
                     bit_idx <= '0;
                     par_bit <= 1'b0;
                     state   <= line_s ? ST_IDLE : ST_DATA;
                  end
               end
               ST_DATA: begin
                  if (full_hit) begin
                     shreg <= {line_s, shreg[DATA_BITS-1:1]};
                     if (bit_idx == IDX_W'(DATA_BITS - 1)) begin
                        state <= (mode == PAR_NONE) ? ST_STOP : ST_PAR;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end
               end
               ST_PAR: begin
                  if (full_hit) begin
                     par_bit <= line_s;
                     state   <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  if (full_hit) begin
                     buf_q  <= shreg;
                     perr_q <= pe_now;
                     ferr_q <= fe_now;
                     done_q <= !(pe_now || fe_now);
                     err_q  <= pe_now || fe_now;
                     state  <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
   parameter int DATA_BITS     = 8,
   parameter int TICKS_PER_BIT = 16,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_en,
   input  logic                 baud_tick,
   input  logic [1:0]           parity_sel,
   input  logic                 rx_line,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_done_irq,
   output logic                 rx_err_irq,
   output logic                 parity_err,
   output logic                 frame_err
);
   generate
      if (TICKS_PER_BIT < 4 || TICKS_PER_BIT > 32) begin : g_bad_tpb
         $error("TICKS_PER_BIT must lie in 4..32");
      end
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_dw
         $error("DATA_BITS must lie in 5..9");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic line_s;
   logic half_hit;
   logic full_hit;
   logic timer_clr;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_line),
      .dout (line_s)
   );

   uart_rx_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (baud_tick),
      .clr     (timer_clr),
      .half_hit(half_hit),
      .full_hit(full_hit)
   );

   uart_rx_frame #(.DATA_BITS(DATA_BITS)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .tick      (baud_tick),
      .line_s    (line_s),
      .half_hit  (half_hit),
      .full_hit  (full_hit),
      .parity_sel(parity_sel),
      .timer_clr (timer_clr),
      .buf_q     (rx_data),
      .done_q    (rx_done_irq),
      .err_q     (rx_err_irq),
      .perr_q    (parity_err),
      .ferr_q    (frame_err)
   );
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rx_en,
   input logic [DATA_BITS-1:0] rx_data,
   input logic                 rx_done_irq,
   input logic                 rx_err_irq,
   input logic                 parity_err,
   input logic                 frame_err
);
   AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_done_irq && rx_err_irq)); // R11
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_irq |=> !rx_done_irq); // R3
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err_irq |=> !rx_err_irq); // R11
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rx_en) |-> (!rx_done_irq && !rx_err_irq)); // R8
   AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_done_irq && !rx_err_irq) |-> $stable(rx_data)); // R3
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_done_irq && !rx_err_irq) |-> $stable({parity_err, frame_err})); // R7
   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err_irq |-> (parity_err || frame_err)); // R5
   AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_irq |-> (!parity_err && !frame_err)); // R7
endmodule

bind uart_rx_core uart_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_en      (rx_en),
   .rx_data    (rx_data),
   .rx_done_irq(rx_done_irq),
   .rx_err_irq (rx_err_irq),
   .parity_err (parity_err),
   .frame_err  (frame_err)
);

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
   localparam int TPB      = 16;
   localparam int TICK_DIV = 2;
   localparam int BITC     = TPB * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       baud_tick = 1'b0;
   logic [1:0] parity_sel = 2'd0;
   logic       rx_line = 1'b1;
   logic [7:0] rx_data;
   logic       rx_done_irq, rx_err_irq, parity_err, frame_err;

   int unsigned n_cmp = 0, n_bad = 0;
   int unsigned done_cnt = 0, err_cnt = 0;
   logic [7:0]  cap_data = 8'h00;
   logic        cap_pe = 1'b0, cap_fe = 1'b0;
   bit          finished = 1'b0;
   int unsigned tdiv = 0;

   uart_rx_core #(.DATA_BITS(8), .TICKS_PER_BIT(TPB), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_tick(baud_tick),
      .parity_sel(parity_sel), .rx_line(rx_line), .rx_data(rx_data),
      .rx_done_irq(rx_done_irq), .rx_err_irq(rx_err_irq),
      .parity_err(parity_err), .frame_err(frame_err)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         tdiv <= 0; baud_tick <= 1'b0;
      end else begin
         tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
         baud_tick <= (tdiv == TICK_DIV - 1);
      end
   end

   always @(negedge clk) begin
      if (rx_done_irq) done_cnt++;
      if (rx_err_irq)  err_cnt++;
      if (rx_done_irq || rx_err_irq) begin
         cap_data = rx_data; cap_pe = parity_err; cap_fe = frame_err;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic par_bit_for(input logic [7:0] d, input logic [1:0] m, input bit flip);
      logic p;
      case (m)
         2'd1:    p = ^d;
         2'd2:    p = ~(^d);
         default: p = 1'b0;
      endcase
      return p ^ flip;
   endfunction

   task automatic hold(input logic v, input int clocks);
      rx_line = v;
      repeat (clocks) @(negedge clk);
   endtask

   // Data, parity and stop bits plus two idle bits; start bit already sent.
   task automatic send_tail(input logic [7:0] d, input logic [1:0] m, input bit bad_par, input bit bad_stop);
      for (int i = 0; i < 8; i++) hold(d[i], BITC);
      if (m != 2'd0) hold(par_bit_for(d, m, bad_par), BITC);
      if (bad_stop) begin
         hold(1'b0, (BITC * 3) / 4);
         hold(1'b1, BITC - (BITC * 3) / 4);
      end else begin
         hold(1'b1, BITC);
      end
      hold(1'b1, 2 * BITC);
   endtask

   task automatic send_frame(input logic [7:0] d, input logic [1:0] m, input bit bad_par, input bit bad_stop);
      parity_sel = m;
      hold(1'b0, BITC);
      send_tail(d, m, bad_par, bad_stop);
   endtask

   task automatic check_frame(input string req, input logic [7:0] d, input logic [1:0] m,
                              input bit bad_par, input bit bad_stop,
                              input int unsigned d0, input int unsigned e0);
      bit exp_pe, exp_err;
      exp_pe  = bad_par && (m != 2'd0);
      exp_err = exp_pe || bad_stop;
      chk({req, " done pulses"}, done_cnt - d0, exp_err ? 0 : 1);
      chk({req, " error pulses"}, err_cnt - e0, exp_err ? 1 : 0);
      chk({req, " buffer"}, cap_data, d);
      chk({req, " parity flag"}, cap_pe, exp_pe);
      chk({req, " framing flag"}, cap_fe, bad_stop);
   endtask

   task automatic frame_case(input string req, input logic [7:0] d, input logic [1:0] m,
                             input bit bad_par, input bit bad_stop);
      int unsigned d0, e0;
      d0 = done_cnt; e0 = err_cnt;
      send_frame(d, m, bad_par, bad_stop);
      check_frame(req, d, m, bad_par, bad_stop, d0, e0);
   endtask

   initial begin
      int unsigned d0, e0;
      logic [7:0]  keep;
      void'($urandom(32'h0BADC0DE));
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 buffer", rx_data, 8'h00);
      chk("R1 flags", {parity_err, frame_err}, 2'b00);
      chk("R1 irqs", {rx_done_irq, rx_err_irq}, 2'b00);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      rx_en = 1'b1;
      hold(1'b1, BITC);

      // Directed data and parity patterns
      frame_case("R3 zeros even", 8'h00, 2'd1, 0, 0);
      frame_case("R3 ones odd", 8'hFF, 2'd2, 0, 0);
      frame_case("R4 no parity slot", 8'hA5, 2'd0, 0, 0);
      frame_case("R4 zero-parity mode", 8'h3C, 2'd3, 0, 0);
      frame_case("R5 bad even parity", 8'h81, 2'd1, 1, 0);
      frame_case("R5 bad zero parity", 8'h7E, 2'd3, 1, 0);
      frame_case("R6 low stop bit", 8'h5A, 2'd0, 0, 1);
      frame_case("R7 flags cleared", 8'hC3, 2'd2, 0, 0);

      // R2: short low glitch is rejected
      d0 = done_cnt; e0 = err_cnt; keep = rx_data;
      hold(1'b0, 2 * TICK_DIV);
      hold(1'b1, 2 * BITC);
      chk("R2 glitch irqs", (done_cnt - d0) + (err_cnt - e0), 0);
      chk("R2 glitch buffer", rx_data, keep);
      frame_case("R2 frame after glitch", 8'h96, 2'd1, 0, 0);

      // R8: abort mid-frame after a flagged frame
      frame_case("R8 setup", 8'h44, 2'd1, 1, 0);
      d0 = done_cnt; e0 = err_cnt; keep = rx_data;
      hold(1'b0, BITC);
      hold(1'b1, BITC); hold(1'b0, BITC); hold(1'b1, BITC);
      rx_en = 1'b0;
      hold(1'b1, 4 * BITC);
      rx_en = 1'b1;
      hold(1'b1, 2 * BITC);
      chk("R8 irqs", (done_cnt - d0) + (err_cnt - e0), 0);
      chk("R8 buffer", rx_data, keep);
      chk("R8 flags", {parity_err, frame_err}, 2'b10);

      // R9: whole frame while disabled
      rx_en = 1'b0;
      d0 = done_cnt; e0 = err_cnt;
      send_frame(8'h11, 2'd0, 0, 0);
      chk("R9 irqs", (done_cnt - d0) + (err_cnt - e0), 0);
      chk("R9 buffer", rx_data, keep);

      // R10: enable raised while line already low
      parity_sel = 2'd1;
      hold(1'b0, 2 * BITC);
      d0 = done_cnt; e0 = err_cnt;
      rx_en = 1'b1;
      hold(1'b0, BITC);
      send_tail(8'hE7, 2'd1, 0, 0);
      check_frame("R10 level start", 8'hE7, 2'd1, 0, 0, d0, e0);

      // Random frames for R3..R7
      for (int k = 0; k < 30; k++) begin
         logic [7:0] d;
         logic [1:0] m;
         bit bp, bs;
         d  = 8'($urandom);
         m  = 2'($urandom);
         bp = ($urandom % 5) == 0;
         bs = ($urandom % 6) == 0;
         frame_case("R3-R7 random", d, m, bp, bs);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule